// File: doc/BRIEF.md
# PCI Power Management Wake Controller

This block holds the power-management capability of a PCI function and turns wake events into the two wake outputs. System software reaches it through a small configuration port. Dword 0 is a read-only capability header. Dword 1 is the control/status word, which holds the power state, the wake enable, a data-select field and the sticky wake status. A wake event from elsewhere in the device, for example a matched wake frame, sets the status bit. The enable bits then decide whether the open-drain PME line is pulled low. A separate wake pin gives one fixed-length pulse whose polarity is programmable.

Two resets are used. `por_n` is the power-on reset and clears every register. `pci_rst_n` is the bus reset. It does not touch the wake status or the wake enable. It returns the power state to D0 on its release only when `rst_clr_en` is set. A `pwr_resume` pulse always returns the power state to D0.

The configuration port carries no stream, so it has no valid/ready handshake and applies no back-pressure. A write is taken in the cycle `cfg_wr` is high. The read data follows `cfg_addr` combinationally and is always valid.

Top module: `pm_wake_ctrl`

## Requirements
- R1: Dword 0 (`cfg_addr`=0) always reads 32'hFE02_0001 and ignores writes. Its fields are: capability ID 01h in [7:0]; next pointer 00h in [15:8]; version 010b in [18:16]; D1 support in [25]; D2 support in [26]; PME support in [31:27], all ones.
- R2: A high `wake_evt` sets the wake status (dword 1 bit 15) at the next edge, whatever the enables are. When a wake event and a status-clearing write fall in the same cycle, the status stays set.
- R3: A write to dword 1 with byte enable 1 and data bit 15 set clears the wake status. If data bit 15 is 0, or byte enable 1 is low, the status is unchanged.
- R4: `pme_drive` is high exactly while the wake status is set and the wake is enabled. The wake is enabled when the wake-enable bit (dword 1 bit 8) is set or when R5 applies.
- R5: When `wol_mode` and `cap_en` are both high, wake is enabled whatever the value of the wake-enable bit. It then enables both `pme_drive` and the wake pulse.
- R6: The power state is dword 1 bits [1:0]: 00=D0, 01=D1, 10=D2, 11=D3hot. It is written through byte enable 0 and is D0 after power-on reset.
- R7: A `pwr_resume` pulse sets the power state to D0. On the release of `pci_rst_n`, the power state goes to D0 only if `rst_clr_en` is high. The wake status and the wake-enable bit survive `pci_rst_n`.
- R8: A wake event sampled while wake is enabled, with no pulse running, starts a pulse of exactly `PULSE_CYC` cycles from that edge. An event during a running pulse neither extends nor restarts it.
- R9: With `pulse_pos`=1, `wake_pin` idles low and pulses high. With `pulse_pos`=0 it idles high and pulses low.
- R10: Data-select (dword 1 bits [12:9]) is read/write through byte enable 1. Data-scale [14:13], bits [7:2] and bits [31:16] read 0. A write with no byte enables changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| pci_rst_n | input | 1 | Bus reset, active low; sticky bits survive it |
| pwr_resume | input | 1 | One-cycle power-resume indication |
| rst_clr_en | input | 1 | Return the power state to D0 when bus reset is released |
| wol_mode | input | 1 | Wake-frame mode selected |
| cap_en | input | 1 | Capability enable; with `wol_mode`, forces wake enable |
| pulse_pos | input | 1 | Wake pulse polarity: 1 positive, 0 negative |
| wake_evt | input | 1 | Wake event strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Dword select: 0 header, 1 control/status |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the dword selected by `cfg_addr` |
| pme_drive | output | 1 | High pulls the open-drain PME line low |
| wake_pin | output | 1 | Wake pulse output |

## Verification
The wake-status bit has two writers that can act in the same cycle: the wake event that sets it and the software write that clears it. The bench raises `wake_evt` in the same cycle as a dword-1 write with bit 15 set. The read-back must still show the status set, because a lost event would mean a missed wake. A second collision is a wake event arriving while a pulse is already running. It is judged by checking that the pin returns to idle exactly `PULSE_CYC` cycles after the first event.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int PS_W   = 2;
  localparam int DSEL_W = 4;

  typedef enum logic [PS_W-1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  localparam logic [7:0] CAP_ID    = 8'h01;
  localparam logic [7:0] CAP_NEXT  = 8'h00;
  localparam logic [2:0] CAP_VER   = 3'b010;
  localparam logic [4:0] PME_FROM  = 5'b11111;

  // Bit positions in the control/status dword that software decodes.
  localparam int BIT_EN   = 8;
  localparam int DSEL_LO  = 9;
  localparam int BIT_STS  = 15;

  function automatic logic [31:0] cap_word();
    return {PME_FROM, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0,
            CAP_VER, CAP_NEXT, CAP_ID};
  endfunction
endpackage

// File: rtl/pmw_csr.sv
module pmw_csr
  import pmw_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              pci_rst_n,
  input  logic              rst_clr_en,
  input  logic              pwr_resume,
  input  logic              wake_evt,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              en_o,
  output logic              sts_o
);
  pstate_e            ps_q;
  logic               en_q;
  logic               sts_q;
  logic [DSEL_W-1:0]  dsel_q;
  logic               bus_rst_q;
  logic               bus_rise;
  logic               lane0_wr;
  logic               lane1_wr;
  logic               sts_clr;
  logic               to_d0;

  assign bus_rise = pci_rst_n & ~bus_rst_q;
  assign lane0_wr = cfg_wr & cfg_addr & cfg_be[0];
  assign lane1_wr = cfg_wr & cfg_addr & cfg_be[1];
  assign sts_clr  = lane1_wr & cfg_wdata[BIT_STS];
  assign to_d0    = pwr_resume | (bus_rise & rst_clr_en);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bus_rst_q <= 1'b0;
      ps_q      <= PS_D0;
      en_q      <= 1'b0;
      sts_q     <= 1'b0;
      dsel_q    <= '0;
    end else begin
      bus_rst_q <= pci_rst_n;
      if (to_d0)
        ps_q <= PS_D0;
      else if (lane0_wr)
        ps_q <= pstate_e'(cfg_wdata[PS_W-1:0]);
      if (lane1_wr) begin
        en_q   <= cfg_wdata[BIT_EN];
        dsel_q <= cfg_wdata[DSEL_LO +: DSEL_W];
      end
      // a new event wins over a clear in the same cycle
      sts_q <= (sts_q & ~sts_clr) | wake_evt;
    end
  end

  always_comb begin
    if (cfg_addr) begin
      cfg_rdata                     = '0;
      cfg_rdata[PS_W-1:0]           = ps_q;
      cfg_rdata[BIT_EN]             = en_q;
      cfg_rdata[DSEL_LO +: DSEL_W]  = dsel_q;
      cfg_rdata[BIT_STS]            = sts_q;
    end else begin
      cfg_rdata = cap_word();
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;

  logic unused_wbits;
  assign unused_wbits = ^{cfg_wdata[31:16], cfg_wdata[14:13], cfg_wdata[7:2], cfg_be[3:2]};

  AST_EVT_SETS_STS: assert property (@(posedge clk) disable iff (!por_n)
    wake_evt |=> sts_q);                                             // R2
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (sts_q && !sts_clr) |=> sts_q);                                  // R3
  AST_RESUME_D0: assert property (@(posedge clk) disable iff (!por_n)
    pwr_resume |=> (ps_q == PS_D0));                                 // R7
  AST_PS_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!cfg_wr && !pwr_resume && !bus_rise) |=> $stable(ps_q));        // R6
endmodule

// File: rtl/pmw_pulse.sv
module pmw_pulse #(
  parameter int PULSE_CYC = 6250000
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  input  logic pos_pol,
  output logic pin_o
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cnt_q <= '0;
    else if (busy)
      cnt_q <= cnt_q - 1'b1;
    else if (trig)
      cnt_q <= LOAD;
  end

  assign pin_o = pos_pol ? busy : ~busy;

  AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (!por_n)
    busy |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));                  // R8
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!por_n)
    (trig && !busy) |=> (cnt_q == LOAD));                            // R8
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl #(
  parameter int PULSE_CYC = 6250000
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        pci_rst_n,
  input  logic        pwr_resume,
  input  logic        rst_clr_en,
  input  logic        wol_mode,
  input  logic        cap_en,
  input  logic        pulse_pos,
  input  logic        wake_evt,
  input  logic        cfg_wr,
  input  logic        cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        pme_drive,
  output logic        wake_pin
);
  logic en_bit;
  logic sts_bit;
  logic wake_ok;

  pmw_csr u_csr (
    .clk        (clk),
    .por_n      (por_n),
    .pci_rst_n  (pci_rst_n),
    .rst_clr_en (rst_clr_en),
    .pwr_resume (pwr_resume),
    .wake_evt   (wake_evt),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .en_o       (en_bit),
    .sts_o      (sts_bit)
  );

  assign wake_ok   = en_bit | (wol_mode & cap_en);
  assign pme_drive = sts_bit & wake_ok;

  pmw_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .por_n   (por_n),
    .trig    (wake_evt & wake_ok),
    .pos_pol (pulse_pos),
    .pin_o   (wake_pin)
  );

  AST_PME_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_wr && cfg_addr && cfg_be[1] && cfg_wdata[15] && !wake_evt) |=> !pme_drive); // R4
endmodule

// File: tb/tb_pm_wake_ctrl.sv
module tb_pm_wake_ctrl;
  localparam int PW = 20;

  logic clk = 1'b0;
  logic por_n = 1'b0, pci_rst_n = 1'b0, pwr_resume = 1'b0, rst_clr_en = 1'b0;
  logic wol_mode = 1'b0, cap_en = 1'b0, pulse_pos = 1'b1, wake_evt = 1'b0;
  logic cfg_wr = 1'b0, cfg_addr = 1'b0;
  logic [3:0] cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic pme_drive, wake_pin;

  int nchk = 0, nfail = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  pm_wake_ctrl #(.PULSE_CYC(PW)) dut (
    .clk(clk), .por_n(por_n), .pci_rst_n(pci_rst_n), .pwr_resume(pwr_resume),
    .rst_clr_en(rst_clr_en), .wol_mode(wol_mode), .cap_en(cap_en),
    .pulse_pos(pulse_pos), .wake_evt(wake_evt), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pme_drive(pme_drive), .wake_pin(wake_pin));

  // monitor: compares read data against queued expectations
  initial forever begin
    @(negedge clk);
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      nchk++;
      if (cfg_rdata !== it.exp) begin
        nfail++;
        $display("FAIL %s: got %h expected %h", it.tag, cfg_rdata, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic a, input logic [31:0] e, input string tag);
    @(posedge clk) #1;
    cfg_addr = a;
    sb_q.push_back('{exp: e, tag: tag});
  endtask

  task automatic wr(input logic a, input logic [3:0] be, input logic [31:0] d);
    @(posedge clk) #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(posedge clk) #1;
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic evt();
    @(posedge clk) #1 wake_evt = 1'b1;
    @(posedge clk) #1 wake_evt = 1'b0;
  endtask

  task automatic chk(input string tag, input logic got, input logic e);
    nchk++;
    if (got !== e) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", tag, got, e);
    end
  endtask

  task automatic pulse_run(input logic act, input string tag);
    for (int k = 1; k <= PW + 1; k++) begin
      @(negedge clk);
      if (k == 1 || k == PW) chk(tag, wake_pin, act);
      if (k == PW + 1) chk(tag, wake_pin, ~act);
      if (k == 5) wake_evt = 1'b1;
      if (k == 6) wake_evt = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1; pci_rst_n = 1'b1;
    expect_rd(1'b0, 32'hFE02_0001, "R1 header");
    expect_rd(1'b1, 32'h0, "R6 reset state");
    @(negedge clk); chk("R4 pme idle", pme_drive, 1'b0); chk("R9 pin idle low", wake_pin, 1'b0);

    wr(1'b1, 4'b0001, 32'h3);                 expect_rd(1'b1, 32'h3, "R6 D3hot");
    wr(1'b1, 4'b0000, 32'hFFFF_FFFF);         expect_rd(1'b1, 32'h3, "R10 no lanes");
    wr(1'b0, 4'hF, 32'hFFFF_FFFF);            expect_rd(1'b0, 32'hFE02_0001, "R1 header write");
    wr(1'b1, 4'hF, 32'hFFFF_7FFF);            expect_rd(1'b1, 32'h1F03, "R10 fields");
    wr(1'b1, 4'b0010, 32'h0);                 expect_rd(1'b1, 32'h3, "R10 dsel cleared");

    evt();
    @(negedge clk); chk("R4 pme disabled", pme_drive, 1'b0); chk("R8 no pulse disabled", wake_pin, 1'b0);
    expect_rd(1'b1, 32'h8003, "R2 status w/o enable");
    wr(1'b1, 4'b0010, 32'h0100);              expect_rd(1'b1, 32'h8103, "R3 write0 keeps");
    @(negedge clk); chk("R4 pme asserted", pme_drive, 1'b1);
    wr(1'b1, 4'b0001, 32'h8003);              expect_rd(1'b1, 32'h8103, "R3 lane1 off keeps");
    wr(1'b1, 4'b0010, 32'h8100);              expect_rd(1'b1, 32'h0103, "R3 w1c");
    @(negedge clk); chk("R4 pme released", pme_drive, 1'b0);

    // same-cycle event and clear
    @(posedge clk) #1;
    cfg_wr = 1'b1; cfg_addr = 1'b1; cfg_be = 4'b0010; cfg_wdata = 32'h8100; wake_evt = 1'b1;
    @(posedge clk) #1; cfg_wr = 1'b0; cfg_be = 4'h0; wake_evt = 1'b0;
    expect_rd(1'b1, 32'h8103, "R2 event beats clear");
    repeat (PW + 4) @(posedge clk);
    wr(1'b1, 4'b0010, 32'h8100);

    evt(); pulse_run(1'b1, "R8 positive pulse");
    wr(1'b1, 4'b0010, 32'h8100);
    pulse_pos = 1'b0;
    @(negedge clk); chk("R9 pin idle high", wake_pin, 1'b1);
    evt(); pulse_run(1'b0, "R9 negative pulse");
    wr(1'b1, 4'b0010, 32'h8000);              expect_rd(1'b1, 32'h0003, "R3 clear en off");

    wol_mode = 1'b1; cap_en = 1'b0;
    evt();
    @(negedge clk); chk("R5 no force", pme_drive, 1'b0); chk("R5 no pulse", wake_pin, 1'b1);
    cap_en = 1'b1;
    @(negedge clk); chk("R5 forced pme", pme_drive, 1'b1);
    evt();
    @(negedge clk); chk("R5 forced pulse", wake_pin, 1'b0);
    repeat (PW + 4) @(posedge clk);
    #1 wol_mode = 1'b0; cap_en = 1'b0;
    @(negedge clk); chk("R4 force removed", pme_drive, 1'b0);

    @(posedge clk) #1 pwr_resume = 1'b1;
    @(posedge clk) #1 pwr_resume = 1'b0;
    expect_rd(1'b1, 32'h8000, "R7 resume D0");
    wr(1'b1, 4'b0011, 32'h0102);              expect_rd(1'b1, 32'h8102, "R6 D2");
    @(posedge clk) #1 pci_rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 pci_rst_n = 1'b1;
    expect_rd(1'b1, 32'h8102, "R7 bus reset keeps");
    rst_clr_en = 1'b1;
    @(posedge clk) #1 pci_rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 pci_rst_n = 1'b1;
    expect_rd(1'b1, 32'h8100, "R7 bus reset D0");
    wr(1'b1, 4'b0010, 32'h8000);              expect_rd(1'b1, 32'h0000, "R3 final clear");

    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule